// File: doc/BRIEF.md
# One-Way Select ROM Access Mux

This block decides which of two requesters may reach a single ROM read port: an internal integrity checker that scans the ROM during boot, or the system bus that uses the ROM afterwards. A 4-bit select input carries the choice as a redundant code. Out of reset the checker owns the port. Once the select moves to the bus, the hand-over is meant to be permanent.

Requests go to the ROM according to the live select. The ROM is taken to answer one cycle after a request. Responses go back according to a registered copy of the select. The block watches both copies. It looks for codes that are neither legal value, and for any return to the checker after the bus has been chosen. Any such event latches a fatal alert that holds until reset. The same event stops the bus from seeing a response-valid, both in the cycle the fault is detected and in every cycle after it.

Top module: `rom_mux_oneway`

## Requirements
- R1: After a synchronous reset, `alert_o` is low and, with `sel_i` = 4'b1010, the checker request and address appear on the ROM port.
- R2: While `sel_i` is 4'b1010 (checker), `rom_req_o`/`rom_addr_o` follow `chk_req_i`/`chk_addr_i` combinationally, and a bus request is not forwarded.
- R3: A ROM response (`rom_rvalid_i`, `rom_rdata_i`) is steered by the select value registered at the previous clock edge; a checker request answered by the ROM one cycle later appears on `chk_rvalid_o`/`chk_rdata_o`.
- R4: While `sel_i` is 4'b0101 (bus), `bus_req_i`/`bus_addr_i` drive the ROM port, the response appears on `bus_rvalid_o`/`bus_rdata_o` one cycle later, and `chk_rvalid_o` stays low.
- R5: A `sel_i` value other than 4'b0101 or 4'b1010 forwards no request (`rom_req_o` low) and raises `alert_o` after the next clock edge.
- R6: If `sel_i` shows 4'b1010 in any cycle after 4'b0101 was seen since reset, `alert_o` rises after that clock edge. The same holds for the registered copy of the select.
- R7: Once high, `alert_o` stays high until reset.
- R8: `bus_rvalid_o` is low in any cycle in which a select fault is being detected or has already been latched.
- R9: A bus request made while the checker is selected never produces a high `bus_rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 4 | Owner select code: 4'b1010 checker, 4'b0101 bus |
| chk_req_i | input | 1 | Checker read request |
| chk_addr_i | input | ADDR_W | Checker word address |
| chk_rvalid_o | output | 1 | Checker response valid |
| chk_rdata_o | output | DATA_W | Checker read data |
| bus_req_i | input | 1 | Bus read request |
| bus_addr_i | input | ADDR_W | Bus word address |
| bus_rvalid_o | output | 1 | Bus response valid, gated by errors |
| bus_rdata_o | output | DATA_W | Bus read data |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | ADDR_W | ROM word address |
| rom_rvalid_i | input | 1 | ROM response valid (one cycle after request) |
| rom_rdata_i | input | DATA_W | ROM read data |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
The bench sends requests from both sides at the same time. A mux that listens to the wrong side would put the bus address on the ROM port while the checker owns it. A mux that routes responses by the live select would hand a checker answer to the bus. The bench flips the select from bus back to checker and also drives an illegal code. A design without the sticky bus-seen flag or without the code check would leave the alert low. Finally, an illegal code placed in the same cycle as a pending bus response shows whether the gate acts on the error at once or only after it has been registered. A design that waits for the register lets one faulty response through.

// File: rtl/rom_mux_pkg.sv
package rom_mux_pkg;

    typedef logic [3:0] sel_code_t;

    localparam sel_code_t SEL_CHECKER = 4'b1010;
    localparam sel_code_t SEL_BUS     = 4'b0101;

    // individual fault causes seen by the select guard
    typedef struct packed {
        logic live_illegal;
        logic held_illegal;
        logic live_reverted;
        logic held_reverted;
    } sel_fault_t;

    function automatic logic code_is_legal(input sel_code_t c);
        return (c == SEL_CHECKER) || (c == SEL_BUS);
    endfunction

    function automatic logic any_fault(input sel_fault_t f);
        return |f;
    endfunction

endpackage

// File: rtl/rom_mux_sel_guard.sv
module rom_mux_sel_guard
    import rom_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sel_code_t  sel_live,
    output sel_code_t  sel_held,
    output sel_fault_t fault
);

    sel_code_t held_q;
    logic      live_bus_seen_q;
    logic      held_bus_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q          <= SEL_CHECKER;
            live_bus_seen_q <= 1'b0;
            held_bus_seen_q <= 1'b0;
        end else begin
            held_q <= sel_live;
            if (sel_live == SEL_BUS) live_bus_seen_q <= 1'b1;
            if (held_q == SEL_BUS)   held_bus_seen_q <= 1'b1;
        end
    end

    always_comb begin
        fault.live_illegal  = !code_is_legal(sel_live);
        fault.held_illegal  = !code_is_legal(held_q);
        fault.live_reverted = live_bus_seen_q && (sel_live == SEL_CHECKER);
        fault.held_reverted = held_bus_seen_q && (held_q == SEL_CHECKER);
    end

    assign sel_held = held_q;

endmodule

// File: rtl/rom_mux_req_path.sv
module rom_mux_req_path
    import rom_mux_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  sel_code_t         sel_live,
    input  logic              chk_req,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr
);

    always_comb begin
        rom_req  = 1'b0;
        rom_addr = '0;
        unique case (sel_live)
            SEL_CHECKER: begin
                rom_req  = chk_req;
                rom_addr = chk_addr;
            end
            SEL_BUS: begin
                rom_req  = bus_req;
                rom_addr = bus_addr;
            end
            default: begin
                rom_req  = 1'b0;
                rom_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/rom_mux_rsp_path.sv
module rom_mux_rsp_path
    import rom_mux_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sel_code_t         sel_held,
    input  logic              block_bus,
    input  logic              rom_rvalid,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              chk_rvalid,
    output logic [DATA_W-1:0] chk_rdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata
);

    assign chk_rvalid = rom_rvalid && (sel_held == SEL_CHECKER);
    assign bus_rvalid = rom_rvalid && (sel_held == SEL_BUS) && !block_bus;
    assign chk_rdata  = rom_rdata;
    assign bus_rdata  = rom_rdata;

endmodule

// File: rtl/rom_mux_oneway.sv
module rom_mux_oneway
    import rom_mux_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        sel_i,
    input  logic              chk_req_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic              chk_rvalid_o,
    output logic [DATA_W-1:0] chk_rdata_o,
    input  logic              bus_req_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic              bus_rvalid_o,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rom_req_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic              rom_rvalid_i,
    input  logic [DATA_W-1:0] rom_rdata_i,
    output logic              alert_o
);

    sel_code_t  sel_held;
    sel_fault_t fault;
    logic       fault_now;
    logic       fault_q;

    rom_mux_sel_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .sel_live (sel_i),
        .sel_held (sel_held),
        .fault    (fault)
    );

    rom_mux_req_path #(.ADDR_W(ADDR_W)) u_req (
        .sel_live (sel_i),
        .chk_req  (chk_req_i),
        .chk_addr (chk_addr_i),
        .bus_req  (bus_req_i),
        .bus_addr (bus_addr_i),
        .rom_req  (rom_req_o),
        .rom_addr (rom_addr_o)
    );

    assign fault_now = any_fault(fault);

    always_ff @(posedge clk) begin
        if (rst)            fault_q <= 1'b0;
        else if (fault_now) fault_q <= 1'b1;
    end

    rom_mux_rsp_path #(.DATA_W(DATA_W)) u_rsp (
        .sel_held   (sel_held),
        .block_bus  (fault_now || fault_q),
        .rom_rvalid (rom_rvalid_i),
        .rom_rdata  (rom_rdata_i),
        .chk_rvalid (chk_rvalid_o),
        .chk_rdata  (chk_rdata_o),
        .bus_rvalid (bus_rvalid_o),
        .bus_rdata  (bus_rdata_o)
    );

    assign alert_o = fault_q;

endmodule

module rom_mux_oneway_chk
    import rom_mux_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        sel_i,
    input logic              chk_req_i,
    input logic [ADDR_W-1:0] chk_addr_i,
    input logic              bus_req_i,
    input logic              bus_rvalid_o,
    input logic              rom_req_o,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              alert_o
);

    a_r2_checker_forward: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_CHECKER) |-> (rom_req_o == chk_req_i && rom_addr_o == chk_addr_i));

    a_r5_illegal_alarm: assert property (@(posedge clk) disable iff (rst)
        !code_is_legal(sel_i) |=> alert_o);

    a_r5_illegal_no_req: assert property (@(posedge clk) disable iff (rst)
        !code_is_legal(sel_i) |-> !rom_req_o);

    a_r6_revert_alarm: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel_i) == SEL_BUS && sel_i == SEL_CHECKER) |=> alert_o);

    a_r7_alert_sticky: assert property (@(posedge clk) disable iff (rst)
        alert_o |=> alert_o);

    a_r8_gate_after_alert: assert property (@(posedge clk) disable iff (rst)
        alert_o |-> !bus_rvalid_o);

    a_r9_no_bus_rsp_under_checker: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_CHECKER && bus_req_i) |=> !bus_rvalid_o);

endmodule

bind rom_mux_oneway rom_mux_oneway_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (sel_i),
    .chk_req_i    (chk_req_i),
    .chk_addr_i   (chk_addr_i),
    .bus_req_i    (bus_req_i),
    .bus_rvalid_o (bus_rvalid_o),
    .rom_req_o    (rom_req_o),
    .rom_addr_o   (rom_addr_o),
    .alert_o      (alert_o)
);

// File: tb/rom_mux_oneway_test.sv
module rom_mux_oneway_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int DW = 32;
    localparam logic [3:0] CHK = 4'b1010;
    localparam logic [3:0] BUS = 4'b0101;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    sel_i;
    logic          chk_req_i, bus_req_i;
    logic [AW-1:0] chk_addr_i, bus_addr_i;
    logic          chk_rvalid_o, bus_rvalid_o, rom_req_o, alert_o;
    logic [DW-1:0] chk_rdata_o, bus_rdata_o;
    logic [AW-1:0] rom_addr_o;
    logic          rom_rvalid_i;
    logic [DW-1:0] rom_rdata_i;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_mux_oneway #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .sel_i(sel_i),
        .chk_req_i(chk_req_i), .chk_addr_i(chk_addr_i),
        .chk_rvalid_o(chk_rvalid_o), .chk_rdata_o(chk_rdata_o),
        .bus_req_i(bus_req_i), .bus_addr_i(bus_addr_i),
        .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o),
        .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o),
        .rom_rvalid_i(rom_rvalid_i), .rom_rdata_i(rom_rdata_i),
        .alert_o(alert_o)
    );

    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        return DW'(a) ^ 32'hC0DE_0000;
    endfunction

    // ROM model: one-cycle read latency
    always @(posedge clk) begin
        rom_rvalid_i <= rom_req_o;
        rom_rdata_i  <= rom_word(rom_addr_o);
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sel_i = CHK;
        chk_req_i = 0; bus_req_i = 0; chk_addr_i = '0; bus_addr_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk_req_i = 1; chk_addr_i = 13'h0011;
        #1;
        check("R1 alert after reset", 64'(alert_o), 64'd0);
        check("R1 rom_req from checker", 64'(rom_req_o), 64'd1);
        check("R1 rom_addr from checker", 64'(rom_addr_o), 64'h11);
        @(negedge clk);
        chk_req_i = 0;
    endtask

    task automatic t_checker_access();
        do_reset();
        @(negedge clk);
        sel_i = CHK; chk_req_i = 1; chk_addr_i = 13'h0005;
        bus_req_i = 1; bus_addr_i = 13'h0009;
        #1;
        check("R2 rom_req under checker", 64'(rom_req_o), 64'd1);
        check("R2 rom_addr is checker addr", 64'(rom_addr_o), 64'h5);
        @(negedge clk);
        chk_req_i = 0;
        #1;
        check("R3 chk_rvalid", 64'(chk_rvalid_o), 64'd1);
        check("R3 chk_rdata", 64'(chk_rdata_o), 64'(rom_word(13'h5)));
        check("R9 bus_rvalid under checker", 64'(bus_rvalid_o), 64'd0);
        check("R2 bus request not forwarded", 64'(rom_req_o), 64'd0);
        @(negedge clk);
        bus_req_i = 0;
        #1;
        check("R9 bus_rvalid still low", 64'(bus_rvalid_o), 64'd0);
    endtask

    task automatic t_bus_access_then_revert();
        do_reset();
        @(negedge clk);
        sel_i = BUS; bus_req_i = 1; bus_addr_i = 13'h0123;
        chk_req_i = 1; chk_addr_i = 13'h0042;
        #1;
        check("R4 rom_addr is bus addr", 64'(rom_addr_o), 64'h123);
        @(negedge clk);
        bus_req_i = 0; chk_req_i = 0;
        #1;
        check("R4 bus_rvalid", 64'(bus_rvalid_o), 64'd1);
        check("R4 bus_rdata", 64'(bus_rdata_o), 64'(rom_word(13'h123)));
        check("R4 chk_rvalid low", 64'(chk_rvalid_o), 64'd0);
        check("R4 no alert on legal switch", 64'(alert_o), 64'd0);
        @(negedge clk);
        sel_i = CHK;
        @(negedge clk);
        check("R6 alert on reversion", 64'(alert_o), 64'd1);
        sel_i = BUS; bus_req_i = 1; bus_addr_i = 13'h0007;
        @(negedge clk);
        bus_req_i = 0;
        #1;
        check("R8 bus_rvalid gated after alert", 64'(bus_rvalid_o), 64'd0);
        repeat (3) @(negedge clk);
        check("R7 alert sticky", 64'(alert_o), 64'd1);
    endtask

    task automatic t_illegal_code();
        do_reset();
        @(negedge clk);
        sel_i = 4'b0000; chk_req_i = 1; bus_req_i = 1;
        #1;
        check("R5 no request on illegal code", 64'(rom_req_o), 64'd0);
        @(negedge clk);
        chk_req_i = 0; bus_req_i = 0; sel_i = CHK;
        check("R5 alert on illegal code", 64'(alert_o), 64'd1);
        do_reset();
        check("R7 reset clears alert", 64'(alert_o), 64'd0);
    endtask

    task automatic t_gate_same_cycle();
        do_reset();
        @(negedge clk);
        sel_i = BUS; bus_req_i = 1; bus_addr_i = 13'h0ABC;
        @(negedge clk);
        bus_req_i = 0; sel_i = 4'b1111;
        #1;
        check("R8 bus_rvalid gated in detect cycle", 64'(bus_rvalid_o), 64'd0);
        check("R8 alert not yet latched", 64'(alert_o), 64'd0);
        @(negedge clk);
        sel_i = BUS;
        check("R5 alert latched", 64'(alert_o), 64'd1);
    endtask

    initial begin
        rst = 1'b1; sel_i = CHK;
        chk_req_i = 0; bus_req_i = 0; chk_addr_i = '0; bus_addr_i = '0;
        t_reset_state();
        t_checker_access();
        t_bus_access_then_revert();
        t_illegal_code();
        t_gate_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule